// File: doc/BRIEF.md
# Proportional Last-Interval Activity Throttler

This block splits one power budget between a processor and its memory system. It counts dispatch pulses and memory-request pulses over fixed intervals of `INTERVAL` cycles. Each count is weighted by a linear power model: a per-event slope plus a constant base term. The two base terms are taken from the budget, and what is left is the dynamic allowance.

When an interval closes, the block compares the activity just seen against that allowance. It scales both counts by allowance over estimated active power and keeps the results as event thresholds for the interval that follows. During that interval, each throttle output rises once its own event count has reached its threshold. It then stays high until the interval ends. Upstream logic is expected to hold back dispatch or request issue while the matching throttle is high.

The scaling divide runs on a bit-serial divider, one quotient bit per cycle. The new thresholds therefore arm a fixed number of cycles after each interval starts.

Top module: `pli_throttler`

## Requirements
- R1: After reset, both throttle outputs stay low until a full interval has completed and its thresholds have been computed. Asserting reset at any time drops both outputs at once.
- R2: An interval lasts exactly `INTERVAL` cycles. Both event counters restart from zero at each boundary, so a throttle raised in one interval does not carry into the next.
- R3: The dynamic allowance is `budget - c_base - m_base`, or 0 when the base terms add up to more than the budget. Estimated active power is `c_slope*D + m_slope*R`, where D and R are the dispatch and request counts of the interval just ended.
- R4: When throttling applies, the dispatch threshold is floor(D × allowance / estimate) and the request threshold is floor(R × allowance / estimate).
- R5: If the estimate is zero or not larger than the allowance, neither output is asserted at any point of the next interval.
- R6: In an interval with thresholds in force, `disp_throttle` is high in every cycle in which the dispatches already counted in that interval are at least the dispatch threshold. It stays high to the interval's end.
- R7: The same rule as R6 holds for `req_throttle`, using the request count and the request threshold.
- R8: New thresholds take effect at cycle `CW+PW` of an interval, where `CW = ceil(log2(INTERVAL+1))`. Both outputs are low in the earlier cycles of that interval.
- R9: The coefficient and budget inputs are sampled in the last cycle of the interval. A pulse in that last cycle counts toward that interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_pulse | input | 1 | One dispatched instruction this cycle |
| req_pulse | input | 1 | One memory request this cycle |
| c_slope | input | PW | Processor power per dispatch |
| c_base | input | PW | Processor constant power |
| m_slope | input | PW | Memory power per request |
| m_base | input | PW | Memory constant power |
| budget | input | PW | Total power budget |
| disp_throttle | output | 1 | Hold back dispatch |
| req_throttle | output | 1 | Hold back memory requests |

## Verification
Each throttle output is a combinational compare of registered counts. A pulse therefore shows its effect one clock edge later, and thresholds from interval k first show at cycle `CW+PW` of interval k+1. The bench keeps its own cycle index within the interval and counts the pulses it has already driven in that interval. At every falling edge it compares both outputs with a prediction built from those counts and the requirement formulas, and only then drives the next cycle's pulses. A reset is also applied mid-interval; both outputs are checked one nanosecond later, and then across the whole first interval after release.

// File: rtl/pli_throttler.sv
module pli_throttler #(
  parameter int INTERVAL = 100000,
  parameter int PW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_pulse,
  input  logic          req_pulse,
  input  logic [PW-1:0] c_slope,
  input  logic [PW-1:0] c_base,
  input  logic [PW-1:0] m_slope,
  input  logic [PW-1:0] m_base,
  input  logic [PW-1:0] budget,
  output logic          disp_throttle,
  output logic          req_throttle
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam int NW = CW + PW;
  localparam int EW = CW + PW + 1;
  localparam int SW = $clog2(NW);
  localparam int IW = $clog2(INTERVAL);

  logic [IW-1:0] ivl_cnt;
  logic [CW-1:0] dcnt, rcnt, d0_q, r0_q, thr_d, thr_r;
  logic [NW-1:0] qd, qr;
  logic [EW-1:0] remd, remr, den;
  logic [SW-1:0] step;
  logic          busy, ready, lim;

  logic last;
  assign last = (ivl_cnt == IW'(INTERVAL - 1));

  logic [CW-1:0] d_now, r_now;
  assign d_now = dcnt + CW'(disp_pulse);
  assign r_now = rcnt + CW'(req_pulse);

  logic [PW:0]   base_sum;
  logic [PW-1:0] pdyn;
  logic [EW-1:0] pest;
  logic          unlim;
  assign base_sum = {1'b0, c_base} + {1'b0, m_base};
  assign pdyn     = ({1'b0, budget} > base_sum) ? (budget - c_base - m_base) : '0;
  assign pest     = EW'(c_slope) * EW'(d_now) + EW'(m_slope) * EW'(r_now);
  assign unlim    = (pest == '0) || (pest <= EW'(pdyn));

  logic [EW:0]   td, tr;
  logic          ged, ger;
  logic [NW-1:0] qd_nx, qr_nx;
  assign td    = {remd, qd[NW-1]};
  assign tr    = {remr, qr[NW-1]};
  assign ged   = td >= {1'b0, den};
  assign ger   = tr >= {1'b0, den};
  assign qd_nx = {qd[NW-2:0], ged};
  assign qr_nx = {qr[NW-2:0], ger};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_cnt <= '0;
      dcnt <= '0; rcnt <= '0; d0_q <= '0; r0_q <= '0;
      thr_d <= '0; thr_r <= '0;
      qd <= '0; qr <= '0; remd <= '0; remr <= '0; den <= '0;
      step <= '0; busy <= 1'b0; ready <= 1'b0; lim <= 1'b0;
    end else begin
      ivl_cnt <= last ? '0 : ivl_cnt + 1'b1;
      if (last) begin
        dcnt  <= '0;
        rcnt  <= '0;
        d0_q  <= d_now;
        r0_q  <= r_now;
        qd    <= NW'(d_now) * NW'(pdyn);
        qr    <= NW'(r_now) * NW'(pdyn);
        remd  <= '0;
        remr  <= '0;
        den   <= pest;
        lim   <= !unlim;
        busy  <= 1'b1;
        ready <= 1'b0;
        step  <= '0;
      end else begin
        dcnt <= d_now;
        rcnt <= r_now;
        if (busy) begin
          remd <= EW'(ged ? td - {1'b0, den} : td);
          remr <= EW'(ger ? tr - {1'b0, den} : tr);
          qd   <= qd_nx;
          qr   <= qr_nx;
          step <= step + 1'b1;
          if (step == SW'(NW - 1)) begin
            busy  <= 1'b0;
            ready <= 1'b1;
            thr_d <= qd_nx[CW-1:0];
            thr_r <= qr_nx[CW-1:0];
          end
        end
      end
    end
  end

  assign disp_throttle = ready && lim && (dcnt >= thr_d);
  assign req_throttle  = ready && lim && (rcnt >= thr_r);

  // R2
  ivl_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (ivl_cnt == '0) && busy && (dcnt == '0) && (rcnt == '0));

  // R6
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_throttle && !last) |=> disp_throttle);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_throttle && !last) |=> req_throttle);

  // R8
  div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!disp_throttle && !req_throttle));

  // R4
  thr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && lim) |-> ((thr_d <= d0_q) && (thr_r <= r0_q)));
endmodule

// File: tb/pli_throttler_bench.sv
`timescale 1ns/1ps
module pli_throttler_bench;
  localparam int INTERVAL = 40;
  localparam int PW = 8;
  localparam int CWB = $clog2(INTERVAL + 1);
  localparam int DLAT = CWB + PW;

  // dn, rn, mode, c_slope, c_base, m_slope, m_base, budget
  localparam int NROW = 10;
  localparam int TBL [NROW][8] = '{
    '{30, 10, 0,   4, 10,   8, 20, 110},  // R4 limited
    '{20, 20, 0,   2,  5,   3,  5, 255},  // R5 estimate below allowance
    '{ 0,  0, 0,   4, 10,   8, 20, 100},  // R5 zero estimate
    '{40, 20, 0,   5, 50,   5, 50,  90},  // R3 allowance saturates to 0
    '{25, 15, 0,   3,  0,   2,  0,  50},  // R4
    '{30, 14, 0,   4, 10,   8, 20, 110},  // R4
    '{ 1,  1, 1, 100,  0, 100,  0, 100},  // R9 pulses on last cycle only
    '{35, 18, 0,   6,  0,   9,  0, 200},  // R4 crossing after arm cycle
    '{25, 15, 0,   2,  0,   0,  0,  50},  // R5 estimate equals allowance
    '{40, 20, 0,   1,  0,   1,  0,   0}   // R3 zero allowance
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_pulse = 1'b0, req_pulse = 1'b0;
  logic [PW-1:0] c_slope = '0, c_base = '0, m_slope = '0, m_base = '0, budget = '0;
  logic disp_throttle, req_throttle;

  always #2.5 clk = ~clk;

  pli_throttler #(.INTERVAL(INTERVAL), .PW(PW)) u_pli_throttler (
    .clk(clk), .rst_n(rst_n), .disp_pulse(disp_pulse), .req_pulse(req_pulse),
    .c_slope(c_slope), .c_base(c_base), .m_slope(m_slope), .m_base(m_base),
    .budget(budget), .disp_throttle(disp_throttle), .req_throttle(req_throttle));

  int compared = 0, mismatched = 0;
  bit have_thr = 0, e_lim = 0;
  int e_td = 0, e_tr = 0;
  string e_tag = "R4";

  task automatic cmp(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_cycle(input int t, input int dseen, input int rseen);
    logic ed, er;
    string bd, br;
    ed = have_thr && (t >= DLAT) && e_lim && (dseen >= e_td);
    er = have_thr && (t >= DLAT) && e_lim && (rseen >= e_tr);
    if (!have_thr) begin bd = "R1"; br = "R1"; end
    else if (t < DLAT) begin bd = "R8/R2"; br = "R8/R2"; end
    else if (!e_lim) begin bd = {"R5/", e_tag}; br = {"R5/", e_tag}; end
    else begin bd = {"R6/", e_tag}; br = {"R7/", e_tag}; end
    cmp(disp_throttle, ed, bd);
    cmp(req_throttle, er, br);
  endtask

  task automatic run_ivl(input int dn, input int rn, input int mode, input int c1,
                         input int c2, input int m1, input int m2, input int bud,
                         input string tag);
    int dseen, rseen, pdyn, pest;
    dseen = 0; rseen = 0;
    c_slope = PW'(c1); c_base = PW'(c2); m_slope = PW'(m1); m_base = PW'(m2); budget = PW'(bud);
    for (int t = 0; t < INTERVAL; t++) begin
      chk_cycle(t, dseen, rseen);
      if (mode == 0) begin
        disp_pulse = (t < dn);
        req_pulse  = (t % 2 == 1) && (t / 2 < rn);
      end else begin
        disp_pulse = (t >= INTERVAL - dn);
        req_pulse  = (t >= INTERVAL - rn);
      end
      if (disp_pulse) dseen++;
      if (req_pulse) rseen++;
      @(negedge clk);
    end
    disp_pulse = 1'b0; req_pulse = 1'b0;
    pdyn = (bud > c2 + m2) ? bud - c2 - m2 : 0;
    pest = c1 * dseen + m1 * rseen;
    e_lim = !((pest == 0) || (pest <= pdyn));
    e_td = e_lim ? (dseen * pdyn) / pest : 0;
    e_tr = e_lim ? (rseen * pdyn) / pest : 0;
    e_tag = tag;
    have_thr = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp(disp_throttle, 1'b0, "R1");
    cmp(req_throttle, 1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      string tg;
      tg = (i == 6) ? "R9" : ((i == 3 || i == 9) ? "R3" : "R4");
      run_ivl(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4],
              TBL[i][5], TBL[i][6], TBL[i][7], tg);
    end
    // zero thresholds in force: throttles up mid-interval, then reset drops them (R1)
    for (int t = 0; t < 20; t++) begin
      chk_cycle(t, 0, 0);
      @(negedge clk);
    end
    cmp(disp_throttle, 1'b1, "R6");
    cmp(req_throttle, 1'b1, "R7");
    rst_n = 1'b0;
    #1;
    cmp(disp_throttle, 1'b0, "R1");
    cmp(req_throttle, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    have_thr = 0;
    run_ivl(40, 20, 0, 1, 0, 1, 0, 0, "R3");
    run_ivl(5, 5, 0, 1, 0, 1, 0, 0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule